// File: doc/BRIEF.md
# Energy-Scalable Iterative Arithmetic Unit

This block is a small arithmetic engine that shares one shift-based datapath among several operations. A caller places an opcode, two 16-bit operands and an iteration budget on the inputs and raises `start` for one cycle. The unit handles two kinds of operation:

- Addition and subtraction finish at once.
- Signed multiplication, unsigned nonrestoring division and unsigned integer square root each spend one clock per iteration.

Each iterative operation produces its most significant result bits first. A smaller iteration budget therefore gives a shorter run with fewer toggling cycles, and the result is a truncated approximation whose low bits are zero.

It suits sensor front ends where the supply of energy varies and the controlling logic trades precision for power from one operation to the next. The unit signals completion with a one-cycle `done` pulse. It accepts a new `start` in the same cycle as that pulse, so operations can be issued back to back.

Top module: `sau_unit`

## Requirements
- R1: Opcode 0 returns the signed sum and opcode 1 the signed difference (opa minus opb) of the two 16-bit operands, sign-extended to 32 bits, with `err` low; `done` is high in the cycle right after the edge that accepts `start`.
- R2: Opcode 2 with a full budget of 16 iterations returns the exact 32-bit signed product of opa and opb.
- R3: Opcode 2 with a budget of n iterations (1 to 15) returns opa times the value of opb with its low 16-n bits cleared, both taken as signed.
- R4: Opcode 3 with a nonzero divisor and a budget of n iterations returns in bits 15:0 the unsigned quotient floor(opa/opb) with its low 16-n bits cleared, and in bits 31:16 the value opa minus that quotient times opb. `err` is low.
- R5: Opcode 4 with a budget of n iterations (maximum 8) returns in bits 7:0 the integer square root of opa with its low 8-n bits cleared, zero in bits 15:8, and opa minus the square of that root in bits 31:16.
- R6: A budget of 0, or one above the opcode's maximum (16 for opcodes 2 and 3, 8 for opcode 4), runs the maximum. An iterative operation holds `busy` high and `done` low until `done` rises n+1 clock edges after the accepting edge. `busy` is low whenever `done` is high.
- R7: Opcode 3 with opb equal to zero sets `err`, returns 16'hFFFF in bits 15:0 and opa in bits 31:16, and completes with the timing of R1.
- R8: Opcodes 5 to 7 set `err`, return zero, and complete with the timing of R1.
- R9: A `start` raised while `busy` is high produces no extra `done` pulse and does not disturb the running operation. A `start` in a cycle where `done` is high is accepted. `result` and `err` change only together with a `done` pulse.
- R10: After reset, `busy`, `done` and `err` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin the operation on the inputs |
| op | input | 3 | Opcode: 0 add, 1 sub, 2 mul, 3 div, 4 sqrt |
| opa | input | 16 | First operand (multiplicand, dividend or radicand) |
| opb | input | 16 | Second operand (multiplier or divisor) |
| iters | input | 5 | Iteration budget; 0 selects the maximum |
| busy | output | 1 | An iterative operation is in progress |
| done | output | 1 | One-cycle completion pulse; result valid |
| err | output | 1 | Division by zero or unused opcode |
| result | output | 32 | Result word, held until the next completion |

## Verification
Two events can fall in one cycle: the completion pulse of one operation and the acceptance of the next `start`. The bench provokes this by issuing each request as soon as `busy` is low, so every single-cycle operation and the end of every iterative run is followed at once by a new request. A scoreboard then demands that each result arrive at its computed cycle with its own value. The opposite case is also covered: a `start` raised in the middle of a multiply must be dropped. That is judged by requiring that no unexpected `done` appears and that the multiply still returns its exact product on time.

// File: rtl/sau_pkg.sv
package sau_pkg;
  localparam int DW = 16;            // operand width
  localparam int PW = 2 * DW;        // result width
  localparam int RW = DW / 2;        // square-root width
  localparam int IW = $clog2(DW) + 1; // iteration budget width
  localparam int AW = PW + 2;        // accumulator / partial remainder width

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_SUB  = 3'd1;
  localparam logic [2:0] OP_MUL  = 3'd2;
  localparam logic [2:0] OP_DIV  = 3'd3;
  localparam logic [2:0] OP_SQRT = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_e;

  // Budget actually used: zero or too large selects the opcode's maximum.
  function automatic logic [IW-1:0] eff_iters(input logic [2:0] op, input logic [IW-1:0] req);
    logic [IW-1:0] lim;
    lim = (op == OP_SQRT) ? IW'(RW) : IW'(DW);
    return (req == '0 || req > lim) ? lim : req;
  endfunction

  // One MSB-first multiplier step; the first bit carries negative weight.
  function automatic logic signed [AW-1:0] mul_step(input logic signed [AW-1:0] acc,
                                                    input logic [DW-1:0] a,
                                                    input logic bbit, input logic first);
    logic signed [AW-1:0] ax;
    ax = $signed({{(AW-DW){a[DW-1]}}, a});
    if (!bbit) return acc <<< 1;
    return first ? (acc <<< 1) - ax : (acc <<< 1) + ax;
  endfunction

  // One nonrestoring step: sign of the partial remainder picks add or subtract.
  function automatic logic signed [AW-1:0] div_step(input logic signed [AW-1:0] p,
                                                    input logic inbit, input logic [DW-1:0] d);
    logic signed [AW-1:0] ps, dx;
    ps = $signed({p[AW-2:0], inbit});
    dx = $signed({{(AW-DW){1'b0}}, d});
    return p[AW-1] ? ps + dx : ps - dx;
  endfunction

  // Final correction: a negative partial remainder gets the divisor back.
  function automatic logic signed [AW-1:0] div_corr(input logic signed [AW-1:0] p,
                                                    input logic [DW-1:0] d);
    return p[AW-1] ? p + $signed({{(AW-DW){1'b0}}, d}) : p;
  endfunction

  // One root bit, decided by squaring the trial value.
  function automatic logic [RW-1:0] sqrt_step(input logic [RW-1:0] root,
                                              input logic [DW-1:0] a, input logic [IW-1:0] idx);
    logic [RW-1:0] trial;
    logic [DW-1:0] sq;
    trial = root | (RW'(1) << (RW - 1 - int'(idx)));
    sq = {{(DW-RW){1'b0}}, trial} * {{(DW-RW){1'b0}}, trial};
    return (sq <= a) ? trial : root;
  endfunction

  function automatic logic [PW-1:0] mul_final(input logic signed [AW-1:0] acc, input logic [IW-1:0] n);
    logic signed [AW-1:0] t;
    t = acc <<< (DW - int'(n));
    return t[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] div_final(input logic signed [AW-1:0] pc, input logic [DW-1:0] q,
                                              input logic [DW-1:0] rest, input logic [IW-1:0] n);
    logic [DW-1:0] quo, rem;
    quo = q << (DW - int'(n));
    rem = (pc[DW-1:0] << (DW - int'(n))) | (rest >> n);
    return {rem, quo};
  endfunction

  function automatic logic [PW-1:0] sqrt_final(input logic [RW-1:0] root, input logic [DW-1:0] a);
    logic [DW-1:0] sq;
    sq = {{(DW-RW){1'b0}}, root} * {{(DW-RW){1'b0}}, root};
    return {a - sq, {(DW-RW){1'b0}}, root};
  endfunction
endpackage

// File: rtl/sau_fast_alu.sv
module sau_fast_alu
  import sau_pkg::*;
(
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [PW-1:0] res,
  output logic          err,
  output logic          need_iter
);
  logic [PW-1:0] sa, sb;
  assign sa = {{DW{a[DW-1]}}, a};
  assign sb = {{DW{b[DW-1]}}, b};

  always_comb begin
    res = '0;
    err = 1'b0;
    need_iter = 1'b0;
    case (op)
      OP_ADD:  res = sa + sb;
      OP_SUB:  res = sa - sb;
      OP_MUL:  need_iter = 1'b1;
      OP_SQRT: need_iter = 1'b1;
      OP_DIV: begin
        if (b == '0) begin
          res = {a, {DW{1'b1}}};
          err = 1'b1;
        end else begin
          need_iter = 1'b1;
        end
      end
      default: err = 1'b1;
    endcase
  end
endmodule

// File: rtl/sau_iter_ctrl.sv
module sau_iter_ctrl
  import sau_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          need_iter,
  input  logic [IW-1:0] n_req,
  output logic          load,
  output logic          step_en,
  output logic [IW-1:0] step_idx,
  output logic          fin,
  output logic          busy,
  output logic [IW-1:0] n_q
);
  st_e           st;
  logic [IW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      n_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start && need_iter) begin
          st  <= S_RUN;
          cnt <= '0;
          n_q <= n_req;
        end
        S_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == n_q - 1'b1) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign load     = start && (st == S_IDLE);
  assign step_en  = (st == S_RUN);
  assign fin      = (st == S_FIN);
  assign busy     = (st != S_IDLE);
  assign step_idx = cnt;

  // R6: iteration index stays inside the latched budget
  p_idx_in_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (step_idx < n_q));

  // R9: a running operation advances one step per edge whatever start does
  p_step_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (fin || (step_en && step_idx == $past(step_idx) + 1'b1)));

  // R6: the finishing state lasts one cycle
  p_fin_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);
endmodule

// File: rtl/sau_shift_dp.sv
module sau_shift_dp
  import sau_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [2:0]    op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          step_en,
  input  logic [IW-1:0] step_idx,
  input  logic          fin,
  input  logic [IW-1:0] n_iter,
  output logic [PW-1:0] res
);
  logic signed [AW-1:0] acc;    // product accumulator or partial remainder
  logic [DW-1:0]        sh;     // bit source shifted out MSB first
  logic [DW-1:0]        opnd;   // held multiplicand, divisor or radicand
  logic [DW-1:0]        qr;     // quotient bits or root
  logic [2:0]           op_q;
  logic signed [AW-1:0] div_nx;
  logic signed [AW-1:0] div_pcorr;
  logic [RW-1:0]        root_nx;

  assign div_nx    = div_step(acc, sh[DW-1], opnd);
  assign div_pcorr = div_corr(acc, opnd);
  assign root_nx   = sqrt_step(qr[RW-1:0], opnd, step_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      sh   <= '0;
      opnd <= '0;
      qr   <= '0;
      op_q <= OP_ADD;
    end else if (load) begin
      acc  <= '0;
      qr   <= '0;
      op_q <= op;
      case (op)
        OP_MUL: begin sh <= opb; opnd <= opa; end
        OP_DIV: begin sh <= opa; opnd <= opb; end
        default: begin sh <= '0; opnd <= opa; end
      endcase
    end else if (step_en) begin
      case (op_q)
        OP_MUL: begin
          acc <= mul_step(acc, opnd, sh[DW-1], step_idx == '0);
          sh  <= sh << 1;
        end
        OP_DIV: begin
          acc <= div_nx;
          sh  <= sh << 1;
          qr  <= {qr[DW-2:0], ~div_nx[AW-1]};
        end
        default: qr[RW-1:0] <= root_nx;
      endcase
    end
  end

  always_comb begin
    case (op_q)
      OP_MUL:  res = mul_final(acc, n_iter);
      OP_DIV:  res = div_final(div_pcorr, qr, sh, n_iter);
      default: res = sqrt_final(qr[RW-1:0], opnd);
    endcase
  end

  // R4: corrected remainder lies in [0, divisor)
  p_div_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_q == OP_DIV) |-> (!div_pcorr[AW-1] && div_pcorr < $signed({{(AW-DW){1'b0}}, opnd})));

  // R5: the square of the root never exceeds the radicand
  p_sqrt_not_over_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_q == OP_SQRT) |->
      (({{(DW-RW){1'b0}}, qr[RW-1:0]} * {{(DW-RW){1'b0}}, qr[RW-1:0]}) <= opnd));
endmodule

// File: rtl/sau_unit.sv
module sau_unit
  import sau_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [IW-1:0] iters,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [PW-1:0] result
);
  logic [PW-1:0] fast_res, dp_res, res_q;
  logic          fast_err, need_iter, load, step_en, fin, done_q, err_q;
  logic [IW-1:0] step_idx, n_q, n_eff;

  assign n_eff = eff_iters(op, iters);

  sau_fast_alu u_fast (
    .op(op), .a(opa), .b(opb), .res(fast_res), .err(fast_err), .need_iter(need_iter)
  );

  sau_iter_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .need_iter(need_iter), .n_req(n_eff),
    .load(load), .step_en(step_en), .step_idx(step_idx), .fin(fin), .busy(busy), .n_q(n_q)
  );

  sau_shift_dp u_dp (
    .clk(clk), .rst_n(rst_n), .load(load), .op(op), .opa(opa), .opb(opb),
    .step_en(step_en), .step_idx(step_idx), .fin(fin), .n_iter(n_q), .res(dp_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      res_q  <= '0;
    end else if (load && !need_iter) begin
      done_q <= 1'b1;
      err_q  <= fast_err;
      res_q  <= fast_res;
    end else if (fin) begin
      done_q <= 1'b1;
      err_q  <= 1'b0;
      res_q  <= dp_res;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done   = done_q;
  assign err    = err_q;
  assign result = res_q;

  // R1: single-cycle operations complete on the next cycle
  p_fast_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !need_iter) |=> (done && !busy));

  // R6: an accepted iterative operation raises busy and withholds done
  p_iter_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && need_iter) |=> (busy && !done));

  // R7: divide by zero flags and returns an all-ones quotient
  p_div_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == OP_DIV && opb == '0) |=> (done && err && result[DW-1:0] == '1));

  // R9: result changes only with a completion pulse
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R6: done and busy never overlap
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/sau_unit_bench.sv
`timescale 1ns/1ps
module sau_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] opa = 16'd0, opb = 16'd0;
  logic [4:0]  iters = 5'd0;
  logic        busy, done, err;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  typedef struct {
    logic [31:0] res;
    logic        err;
    int          due;
    string       tag;
  } exp_t;
  exp_t sb[$];

  sau_unit u_sau_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .iters(iters), .busy(busy), .done(done), .err(err), .result(result)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic int budget(input logic [2:0] o, input logic [4:0] it);
    int mx;
    mx = (o == 3'd4) ? 8 : 16;
    return (it == 0 || int'(it) > mx) ? mx : int'(it);
  endfunction

  function automatic int root_of(input logic [15:0] a);
    int r = 0;
    while ((r + 1) * (r + 1) <= int'(a)) r++;
    return r;
  endfunction

  task automatic issue(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                       input logic [4:0] it, input string tag);
    exp_t e;
    int n, k, lat, q, r, sa, sbm;
    logic [15:0] bm;
    while (busy) @(negedge clk);
    n = budget(o, it);
    k = 16 - n;
    e.err = 1'b0;
    lat = n + 2;
    case (o)
      3'd0: begin e.res = 32'($signed(a)) + 32'($signed(b)); lat = 1; end
      3'd1: begin e.res = 32'($signed(a)) - 32'($signed(b)); lat = 1; end
      3'd2: begin
        bm  = b & ~((16'd1 << k) - 16'd1);
        sa  = int'($signed(a));
        sbm = int'($signed(bm));
        e.res = 32'(sa * sbm);
      end
      3'd3: begin
        if (b == 16'd0) begin
          e.res = {a, 16'hFFFF}; e.err = 1'b1; lat = 1;
        end else begin
          q = (int'(a) / int'(b)) & ~((1 << k) - 1);
          r = int'(a) - q * int'(b);
          e.res = {r[15:0], q[15:0]};
        end
      end
      3'd4: begin
        k = 8 - n;
        q = root_of(a) & ~((1 << k) - 1);
        r = int'(a) - q * q;
        e.res = {r[15:0], 8'd0, q[7:0]};
      end
      default: begin e.res = 32'd0; e.err = 1'b1; lat = 1; end
    endcase
    e.due = cyc + lat;
    e.tag = tag;
    sb.push_back(e);
    start = 1'b1; op = o; opa = a; opb = b; iters = it;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected done", result, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result === e.res, {e.tag, " result"}, result, e.res);
        check(err === e.err, {e.tag, " err"}, {31'd0, err}, {31'd0, e.err});
        check(cyc == e.due, {e.tag, " R6 latency"}, cyc, e.due);
        check(busy === 1'b0, {e.tag, " R6 busy low at done"}, {31'd0, busy}, 32'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy === 1'b0, "R10 busy", {31'd0, busy}, 32'd0);
    check(done === 1'b0, "R10 done", {31'd0, done}, 32'd0);
    check(err === 1'b0, "R10 err", {31'd0, err}, 32'd0);
    check(result === 32'd0, "R10 result", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 add/sub, issued back to back (R9: start alongside done)
    issue(3'd0, 16'd100, 16'hFFFB, 5'd0, "R1 add");
    issue(3'd1, 16'd3, 16'd10, 5'd0, "R1 sub");
    issue(3'd0, 16'h7FFF, 16'h7FFF, 5'd0, "R1 add max");
    issue(3'd1, 16'h8000, 16'h0001, 5'd0, "R1 sub min");

    // R2 full multiply
    issue(3'd2, 16'hFFFD, 16'd7, 5'd16, "R2 mul neg");
    issue(3'd2, 16'h8000, 16'h8000, 5'd0, "R2 mul minmin");
    issue(3'd2, 16'd1234, 16'hFDC9, 5'd31, "R2 mul clamp");

    // R3 reduced multiply
    issue(3'd2, 16'd1000, 16'h0FFF, 5'd8, "R3 mul n8");
    issue(3'd2, 16'd77, 16'h8001, 5'd1, "R3 mul n1");

    // R4 division
    issue(3'd3, 16'd100, 16'd7, 5'd0, "R4 div");
    issue(3'd3, 16'hFFFF, 16'd1, 5'd16, "R4 div by one");
    issue(3'd3, 16'd50000, 16'd300, 5'd8, "R4 div n8");
    issue(3'd3, 16'd60000, 16'd3, 5'd10, "R4 div n10");
    issue(3'd3, 16'd5, 16'd9, 5'd20, "R4 div small clamp");

    // R7 division by zero
    issue(3'd3, 16'd1234, 16'd0, 5'd0, "R7 div zero");

    // R5 square root
    issue(3'd4, 16'hFFFF, 16'd0, 5'd0, "R5 sqrt max");
    issue(3'd4, 16'd17, 16'd0, 5'd8, "R5 sqrt 17");
    issue(3'd4, 16'd0, 16'd0, 5'd0, "R5 sqrt zero");
    issue(3'd4, 16'd200, 16'd0, 5'd4, "R5 sqrt n4");
    issue(3'd4, 16'd10000, 16'd0, 5'd5, "R5 sqrt n5");
    issue(3'd4, 16'd50, 16'd0, 5'd12, "R5 R6 sqrt clamp");

    // R8 unused opcodes
    issue(3'd6, 16'd9, 16'd9, 5'd0, "R8 op6");
    issue(3'd7, 16'd1, 16'd2, 5'd3, "R8 op7");

    // R9: start while busy is ignored
    issue(3'd2, 16'd321, 16'd123, 5'd0, "R9 mul under poke");
    repeat (3) @(negedge clk);
    check(busy === 1'b1, "R6 busy mid-run", {31'd0, busy}, 32'd1);
    start = 1'b1; op = 3'd0; opa = 16'd1; opb = 16'd1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    check(done === 1'b0, "R9 no done from ignored start", {31'd0, done}, 32'd0);

    while (sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(result === 32'(321 * 123), "R9 result held", result, 32'(321 * 123));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule